// File: doc/BRIEF.md
# Word Cache Controller

This block is a configurable cache that sits between a 16-bit pipelined CPU and external RAM. The CPU raises a request for one 16-bit word, either a read (instruction fetch or data load) or a write (store), and holds it until the block pulses an acknowledge. For every request the block decides what happens to the memory operation behind it. The operation may be dropped because the cache can answer it alone. It may go out unchanged. It may be swapped for a write of a dirty victim line. Each cache line holds a single word with valid, dirty and tag bits.

Parameters set the number of sets and ways. The capacity in data bits is sets × ways × 16, and one set of many ways gives a fully associative cache. Further parameters choose write-back or write-through, write-allocate or write-no-allocate, and FIFO or pseudo-random victim selection. The memory port does reads in one cycle and holds a write for three cycles. The CPU sees a stall flag in every cycle in which that port is busy.

The controller has six states. IDLE accepts a request and moves to LOOKUP. LOOKUP compares tags and branches:
- to DONE for a read hit, or for a write-back write that needs no eviction;
- to EVICT when a dirty victim must go to memory;
- to FILL for a read miss with a clean victim;
- to WTHRU for a write that memory has to see.

EVICT runs for three cycles. It then moves to FILL for a read, or installs the store and moves to DONE for a write. FILL reads for one cycle, installs the word and moves to DONE. WTHRU writes for three cycles, updates the cache when allowed, and moves to DONE. DONE pulses the acknowledge and returns to IDLE.

Top module: `cpu_word_cache`

## Requirements
- R1: After reset every line is invalid and clean; cpu_ack, cpu_stall, mem_rd and mem_wr are low, and the first read of any address misses and fetches from memory.
- R2: A read hit returns the cached word with no memory read or write and no stall cycle.
- R3: A read miss whose victim is invalid or clean performs exactly one memory read of the requested address, returns that word and installs it clean.
- R4: In write-back mode a read miss whose victim is valid and dirty first writes the victim's word to the victim's address ({tag, set index}), then reads the requested word.
- R5: In write-back, write-allocate mode a write miss with a clean or invalid victim issues no memory operation and stores the word in the cache as dirty.
- R6: In write-back, write-allocate mode a write miss with a dirty victim issues one memory write carrying the victim's address and data (no read), then holds the store data in the cache as dirty.
- R7: In write-back mode a write hit issues no memory operation and updates the cached word, which is marked dirty and later reaches memory when evicted.
- R8: In write-through mode a write hit writes memory and updates the cached word; read misses never cause a memory write.
- R9: With write-no-allocate a write miss writes memory and leaves the cache unchanged, so a following read of that address misses.
- R10: mem_rd is high for exactly one cycle per read; mem_wr stays high for exactly three consecutive cycles per write; the two are never high together.
- R11: cpu_stall is high exactly in the cycles in which mem_rd or mem_wr is high.
- R12: In FIFO mode each set keeps a victim pointer, starting at way 0 after reset, that moves to the next way (wrapping) on every install after a miss; hits do not move it. The set index is the low log2(sets) address bits and the tag is the remaining upper bits.
- R13: cpu_ack is a one-cycle pulse per request, and cpu_rdata holds the read word while cpu_ack is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write (store), 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Store data |
| cpu_rdata | output | 16 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Request complete, one-cycle pulse |
| cpu_stall | output | 1 | Memory side busy |
| mem_rd | output | 1 | Memory read strobe, one cycle |
| mem_wr | output | 1 | Memory write strobe, three cycles |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, sampled in the read cycle |

## Verification
A wrong valid, tag or dirty bit is invisible until that line is touched again. A lost dirty bit shows up only when that line is evicted: the write-back is missing at the memory port, and the stale word appears on a later miss to that address. A wrong FIFO pointer picks the wrong victim, so the write-back carries the wrong address and data. A wrong hit decision shows up within the same request as an extra or missing memory strobe and stall. The directed cases therefore revisit each set after forcing dirty evictions, and compare the order, addresses and data of the memory traffic as well as the returned words.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_DONE
    } cache_state_e;

    // Galois step, polynomial x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [15:0] lfsr16_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

endpackage

// File: rtl/cache_store.sv
`timescale 1ns/1ps
module cache_store #(
    parameter int WAYS   = 2,
    parameter int SETS   = 8,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 16,
    parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int SET_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    input  logic [TAG_W-1:0]             rd_tag,
    output logic                         hit,
    output logic [WAY_W-1:0]             hit_way,
    output logic [WAYS-1:0]              way_valid,
    output logic [WAYS-1:0]              way_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    output logic [WAYS-1:0][DATA_W-1:0]  way_data,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         wr_dirty
);

    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            way_valid[w] = valid_q[rd_set][w];
            way_dirty[w] = dirty_q[rd_set][w];
            way_tag[w]   = tag_q[rd_set][w];
            way_data[w]  = data_q[rd_set][w];
            hit_vec[w]   = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        hit = |hit_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[rd_set][wr_way] <= 1'b1;
            dirty_q[rd_set][wr_way] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[rd_set][wr_way]  <= wr_tag;
            data_q[rd_set][wr_way] <= wr_data;
        end
    end

    // A tag may live in only one way of a set (R3: installs never duplicate)
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/cache_victim.sv
`timescale 1ns/1ps
module cache_victim
    import cache_pkg::*;
#(
    parameter int WAYS   = 2,
    parameter int SETS   = 8,
    parameter bit RANDOM = 1'b0,
    parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int SET_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set,
    input  logic             advance,
    output logic [WAY_W-1:0] victim_way
);

    logic [15:0]      lfsr_q;
    logic [WAY_W-1:0] ptr_q [SETS];
    logic [WAY_W-1:0] rnd_way;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= 16'hACE1;
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else begin
            lfsr_q <= lfsr16_next(lfsr_q);
            if (advance) begin
                ptr_q[set] <= (ptr_q[set] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[set] + 1'b1;
            end
        end
    end

    assign rnd_way = WAY_W'(32'(lfsr_q[WAY_W-1:0]) % WAYS);

    generate
        if (RANDOM) begin : g_random
            assign victim_way = rnd_way;
        end else begin : g_fifo
            assign victim_way = ptr_q[set];
        end
    endgenerate

    // FIFO pointer must move after every install (R12)
    assert_fifo_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !RANDOM && WAYS > 1) |=> (victim_way != $past(victim_way)));

endmodule

// File: rtl/cache_ctrl.sv
`timescale 1ns/1ps
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int WAYS       = 2,
    parameter int SETS       = 8,
    parameter bit WRITE_BACK = 1'b1,
    parameter bit WR_ALLOC   = 1'b1,
    parameter int WR_CYCLES  = 3,
    parameter int IDX_BITS   = (SETS > 1) ? $clog2(SETS) : 0,
    parameter int TAG_W      = ADDR_W - IDX_BITS,
    parameter int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int SET_W      = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic                        cpu_ack,
    output logic                        cpu_stall,
    output logic                        mem_rd,
    output logic                        mem_wr,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic [SET_W-1:0]            lk_set,
    output logic [TAG_W-1:0]            lk_tag,
    input  logic                        hit,
    input  logic [WAY_W-1:0]            hit_way,
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0]             way_dirty,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][DATA_W-1:0] way_data,
    input  logic [WAY_W-1:0]            victim_way,
    output logic                        fill_adv,
    output logic                        wr_en,
    output logic [WAY_W-1:0]            wr_way,
    output logic [TAG_W-1:0]            wr_tag,
    output logic [DATA_W-1:0]           wr_data,
    output logic                        wr_dirty
);

    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    cache_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              we_q, hit_q;
    logic [WAY_W-1:0]  hway_q, vway_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] evict_addr;
    logic              wr_last, victim_dirty;

    generate
        if (IDX_BITS > 0) begin : g_indexed
            assign lk_set     = addr_q[IDX_BITS-1:0];
            assign evict_addr = {way_tag[vway_q], lk_set};
        end else begin : g_single_set
            assign lk_set     = '0;
            assign evict_addr = way_tag[vway_q];
        end
    endgenerate
    assign lk_tag = addr_q[ADDR_W-1:IDX_BITS];

    assign wr_last      = (cnt_q == CNT_W'(WR_CYCLES - 1));
    assign victim_dirty = WRITE_BACK && way_valid[victim_way] && way_dirty[victim_way];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            hit_q   <= 1'b0;
            hway_q  <= '0;
            vway_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
                we_q    <= cpu_we;
            end
            if (state_q == ST_LOOKUP) begin
                hit_q  <= hit;
                hway_q <= hit_way;
                vway_q <= victim_way;
                if (hit && !we_q) rdata_q <= way_data[hit_way];
            end
            if (state_q == ST_FILL) rdata_q <= mem_rdata;
            if ((state_q == ST_EVICT || state_q == ST_WTHRU) && state_d == state_q)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        wr_en     = 1'b0;
        wr_way    = vway_q;
        wr_tag    = lk_tag;
        wr_data   = wdata_q;
        wr_dirty  = 1'b0;
        fill_adv  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (!we_q) begin
                    if (hit)               state_d = ST_DONE;
                    else if (victim_dirty) state_d = ST_EVICT;
                    else                   state_d = ST_FILL;
                end else if (hit) begin
                    if (WRITE_BACK) begin
                        wr_en    = 1'b1;
                        wr_way   = hit_way;
                        wr_dirty = 1'b1;
                        state_d  = ST_DONE;
                    end else begin
                        state_d  = ST_WTHRU;
                    end
                end else if (!WR_ALLOC || !WRITE_BACK) begin
                    state_d = ST_WTHRU;
                end else if (victim_dirty) begin
                    state_d = ST_EVICT;
                end else begin
                    wr_en    = 1'b1;
                    wr_way   = victim_way;
                    wr_dirty = 1'b1;
                    fill_adv = 1'b1;
                    state_d  = ST_DONE;
                end
            end
            ST_EVICT: begin
                mem_wr    = 1'b1;
                mem_addr  = evict_addr;
                mem_wdata = way_data[vway_q];
                if (wr_last) begin
                    if (we_q) begin
                        wr_en    = 1'b1;
                        wr_dirty = 1'b1;
                        fill_adv = 1'b1;
                        state_d  = ST_DONE;
                    end else begin
                        state_d  = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_rd   = 1'b1;
                wr_en    = 1'b1;
                wr_data  = mem_rdata;
                fill_adv = 1'b1;
                state_d  = ST_DONE;
            end
            ST_WTHRU: begin
                mem_wr = 1'b1;
                if (wr_last) begin
                    if (hit_q) begin
                        wr_en  = 1'b1;
                        wr_way = hway_q;
                    end else if (WR_ALLOC) begin
                        wr_en    = 1'b1;
                        fill_adv = 1'b1;
                    end
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cpu_ack   = (state_q == ST_DONE);
    assign cpu_stall = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_WTHRU);
    assign cpu_rdata = rdata_q;

    // Checker state: length of the current write burst
    logic [7:0] wr_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wr_run <= '0;
        else if (mem_wr) wr_run <= wr_run + 1'b1;
        else             wr_run <= '0;
    end

    assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_read_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    assert_write_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr) |-> (wr_run == 8'(WR_CYCLES)));
    assert_stall_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall == (mem_rd || mem_wr));
    assert_hit_cancel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && hit && !we_q) |=> (cpu_ack && !mem_rd && !mem_wr));
    assert_ack_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

endmodule

// File: rtl/cpu_word_cache.sv
`timescale 1ns/1ps
module cpu_word_cache #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SETS        = 8,
    parameter int WAYS        = 2,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WR_ALLOC    = 1'b1,
    parameter bit REPL_RANDOM = 1'b0,
    parameter int WR_CYCLES   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_stall,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_BITS = (SETS > 1) ? $clog2(SETS) : 0;
    localparam int TAG_W    = ADDR_W - IDX_BITS;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int SET_W    = (SETS > 1) ? $clog2(SETS) : 1;

    logic [SET_W-1:0]            lk_set;
    logic [TAG_W-1:0]            lk_tag;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WAYS-1:0]             way_valid, way_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0][DATA_W-1:0] way_data;
    logic [WAY_W-1:0]            victim_way;
    logic                        fill_adv;
    logic                        wr_en, wr_dirty;
    logic [WAY_W-1:0]            wr_way;
    logic [TAG_W-1:0]            wr_tag;
    logic [DATA_W-1:0]           wr_data;

    cache_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W),
        .WAY_W(WAY_W), .SET_W(SET_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_set(lk_set), .rd_tag(lk_tag),
        .hit(hit), .hit_way(hit_way),
        .way_valid(way_valid), .way_dirty(way_dirty),
        .way_tag(way_tag), .way_data(way_data),
        .wr_en(wr_en), .wr_way(wr_way), .wr_tag(wr_tag),
        .wr_data(wr_data), .wr_dirty(wr_dirty)
    );

    cache_victim #(
        .WAYS(WAYS), .SETS(SETS), .RANDOM(REPL_RANDOM),
        .WAY_W(WAY_W), .SET_W(SET_W)
    ) u_victim (
        .clk(clk), .rst_n(rst_n),
        .set(lk_set), .advance(fill_adv), .victim_way(victim_way)
    );

    cache_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS),
        .WRITE_BACK(WRITE_BACK), .WR_ALLOC(WR_ALLOC), .WR_CYCLES(WR_CYCLES),
        .IDX_BITS(IDX_BITS), .TAG_W(TAG_W), .WAY_W(WAY_W), .SET_W(SET_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .cpu_stall(cpu_stall),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .lk_set(lk_set), .lk_tag(lk_tag),
        .hit(hit), .hit_way(hit_way),
        .way_valid(way_valid), .way_dirty(way_dirty),
        .way_tag(way_tag), .way_data(way_data),
        .victim_way(victim_way), .fill_adv(fill_adv),
        .wr_en(wr_en), .wr_way(wr_way), .wr_tag(wr_tag),
        .wr_data(wr_data), .wr_dirty(wr_dirty)
    );

endmodule

// File: tb/cpu_word_cache_bench.sv
`timescale 1ns/1ps
module cpu_word_cache_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // shared CPU-side drive; sel picks the instance (0 = write-back, 1 = write-through)
    logic        sel = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [15:0] addr = '0, wdata = '0;

    logic [15:0] a_rdata, b_rdata, a_maddr, b_maddr, a_mwdata, b_mwdata, m_rdata;
    logic        a_ack, b_ack, a_stall, b_stall, a_mrd, b_mrd, a_mwr, b_mwr;

    cpu_word_cache u_cpu_word_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(req && !sel), .cpu_we(we), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_rdata(a_rdata), .cpu_ack(a_ack), .cpu_stall(a_stall),
        .mem_rd(a_mrd), .mem_wr(a_mwr), .mem_addr(a_maddr),
        .mem_wdata(a_mwdata), .mem_rdata(m_rdata)
    );

    cpu_word_cache #(.WRITE_BACK(1'b0), .WR_ALLOC(1'b0), .REPL_RANDOM(1'b1)) u_cpu_word_cache_wt (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(req && sel), .cpu_we(we), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_rdata(b_rdata), .cpu_ack(b_ack), .cpu_stall(b_stall),
        .mem_rd(b_mrd), .mem_wr(b_mwr), .mem_addr(b_maddr),
        .mem_wdata(b_mwdata), .mem_rdata(m_rdata)
    );

    wire        ack   = sel ? b_ack   : a_ack;
    wire [15:0] rdata = sel ? b_rdata : a_rdata;
    wire        stall = sel ? b_stall : a_stall;
    wire        m_rd  = sel ? b_mrd   : a_mrd;
    wire        m_wr  = sel ? b_mwr   : a_mwr;
    wire [15:0] m_addr  = sel ? b_maddr  : a_maddr;
    wire [15:0] m_wdata = sel ? b_mwdata : a_mwdata;

    // memory model: 256 words, combinational read, write commits on 3rd cycle
    logic [15:0] mem [256];
    assign m_rdata = mem[m_addr[7:0]];

    function automatic logic [15:0] orig(input int a);
        return 16'(a * 257) ^ 16'h5A3C;
    endfunction

    int n_chk = 0, n_bad = 0;
    bit in_acc = 1'b0, seen_op, first_wr, finished = 1'b0;
    int rd_cyc, wr_cyc, stall_cyc, stall_bad, ack_cyc, wr_txn, wcnt = 0;
    logic [15:0] last_waddr, last_wdata, got;

    always @(posedge clk) begin
        if (m_wr) begin
            if (wcnt == 2) begin
                mem[m_addr[7:0]] = m_wdata;
                wcnt = 0;
                if (in_acc) begin
                    wr_txn++;
                    last_waddr = m_addr;
                    last_wdata = m_wdata;
                end
            end else wcnt++;
        end else wcnt = 0;
        if (in_acc) begin
            if (m_rd) rd_cyc++;
            if (m_wr) wr_cyc++;
            if (stall) stall_cyc++;
            if (stall != (m_rd || m_wr)) stall_bad++;
            if (ack) ack_cyc++;
            if ((m_rd || m_wr) && !seen_op) begin
                seen_op = 1'b1;
                first_wr = m_wr;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit s, input bit w, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = s; we = w; addr = a; wdata = d;
        rd_cyc = 0; wr_cyc = 0; stall_cyc = 0; stall_bad = 0; ack_cyc = 0;
        wr_txn = 0; seen_op = 1'b0; first_wr = 1'b0;
        last_waddr = 'x; last_wdata = 'x;
        req = 1'b1; in_acc = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ack) break;
        end
        chk("R13 ack seen", {15'd0, ack}, 16'd1);
        got = rdata;
        req = 1'b0;
        @(negedge clk);
        in_acc = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ack low", {15'd0, a_ack}, 16'd0);
        chk("R1 stall low", {15'd0, a_stall}, 16'd0);
        chk("R1 mem_rd low", {15'd0, a_mrd}, 16'd0);
        chk("R1 mem_wr low", {15'd0, a_mwr}, 16'd0);
    endtask

    task automatic t_read_miss_clean;
        access(0, 0, 16'h0010, 0);
        chk("R3 miss data", got, orig(16'h10));
        chk("R3 one read", 16'(rd_cyc), 16'd1);
        chk("R3 no write", 16'(wr_cyc), 16'd0);
        chk("R13 single ack", 16'(ack_cyc), 16'd1);
    endtask

    task automatic t_read_hit;
        access(0, 0, 16'h0010, 0);
        chk("R2 hit data", got, orig(16'h10));
        chk("R2 no read", 16'(rd_cyc), 16'd0);
        chk("R2 no write", 16'(wr_cyc), 16'd0);
        chk("R2 no stall", 16'(stall_cyc), 16'd0);
    endtask

    task automatic t_write_hit_wb;
        access(0, 1, 16'h0010, 16'h1234);
        chk("R7 no mem op", 16'(rd_cyc + wr_cyc), 16'd0);
        chk("R7 memory untouched", mem[16'h10], orig(16'h10));
        access(0, 0, 16'h0010, 0);
        chk("R7 cached new word", got, 16'h1234);
        chk("R7 readback hit", 16'(rd_cyc), 16'd0);
    endtask

    task automatic t_write_miss_clean;
        access(0, 1, 16'h0020, 16'h5678);   // set 0, FIFO points at way 1 (empty)
        chk("R5 no mem op", 16'(rd_cyc + wr_cyc), 16'd0);
        chk("R5 memory untouched", mem[16'h20], orig(16'h20));
        access(0, 0, 16'h0020, 0);
        chk("R5 cached store", got, 16'h5678);
        chk("R5 readback hit", 16'(rd_cyc), 16'd0);
    endtask

    task automatic t_read_miss_dirty;
        access(0, 0, 16'h0030, 0);          // FIFO wraps to way 0 holding dirty 0x10
        chk("R4 one victim write", 16'(wr_txn), 16'd1);
        chk("R4 write first", {15'd0, first_wr}, 16'd1);
        chk("R12 victim address", last_waddr, 16'h0010);
        chk("R4 victim data", last_wdata, 16'h1234);
        chk("R4 then one read", 16'(rd_cyc), 16'd1);
        chk("R4 miss data", got, orig(16'h30));
        chk("R10 write three cycles", 16'(wr_cyc), 16'd3);
        chk("R11 stall count", 16'(stall_cyc), 16'd4);
        chk("R11 stall tracks busy", 16'(stall_bad), 16'd0);
    endtask

    task automatic t_write_miss_dirty;
        access(0, 1, 16'h0040, 16'h9ABC);   // victim way 1 holding dirty 0x20
        chk("R6 one write", 16'(wr_txn), 16'd1);
        chk("R6 victim address", last_waddr, 16'h0020);
        chk("R6 victim data", last_wdata, 16'h5678);
        chk("R6 no read", 16'(rd_cyc), 16'd0);
        chk("R6 store not in memory", mem[16'h40], orig(16'h40));
        access(0, 0, 16'h0040, 0);
        chk("R6 cached store", got, 16'h9ABC);
        chk("R6 readback hit", 16'(rd_cyc), 16'd0);
        access(0, 0, 16'h0030, 0);
        chk("R12 other way kept", got, orig(16'h30));
        chk("R12 other way hit", 16'(rd_cyc), 16'd0);
    endtask

    task automatic t_reset_clears;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        access(0, 0, 16'h0040, 0);
        chk("R1 miss after reset", 16'(rd_cyc), 16'd1);
        chk("R1 memory word", got, orig(16'h40));
        chk("R1 no write-back", 16'(wr_cyc), 16'd0);
    endtask

    task automatic t_wt_write_miss;
        access(1, 1, 16'h0050, 16'h1111);
        chk("R9 memory written", mem[16'h50], 16'h1111);
        chk("R9 one write", 16'(wr_txn), 16'd1);
        chk("R10 write three cycles", 16'(wr_cyc), 16'd3);
        chk("R11 stall tracks busy", 16'(stall_bad), 16'd0);
        access(1, 0, 16'h0050, 0);
        chk("R9 not allocated", 16'(rd_cyc), 16'd1);
        chk("R9 read data", got, 16'h1111);
    endtask

    task automatic t_wt_write_hit;
        access(1, 1, 16'h0050, 16'h2222);
        chk("R8 memory written", mem[16'h50], 16'h2222);
        chk("R8 one write", 16'(wr_txn), 16'd1);
        access(1, 0, 16'h0050, 0);
        chk("R8 cache updated", got, 16'h2222);
        chk("R8 readback hit", 16'(rd_cyc), 16'd0);
    endtask

    task automatic t_wt_no_evict;
        for (int k = 6; k < 10; k++) begin
            access(1, 0, 16'(k * 16), 0);
            chk("R8 read miss no write", 16'(wr_cyc), 16'd0);
            chk("R8 read miss data", got, orig(k * 16));
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = orig(i);
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_read_miss_clean;
        t_read_hit;
        t_write_hit_wb;
        t_write_miss_clean;
        t_read_miss_dirty;
        t_write_miss_dirty;
        t_reset_clears;
        t_wt_write_miss;
        t_wt_write_hit;
        t_wt_no_evict;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule